// File: doc/BRIEF.md
# Flash Command Launch Controller

This block is the register front end of an embedded flash controller. A CPU stages a command over a simple register bus: one opcode word, then up to four parameter words, each selected through an index register. Writing 1 to the launch bit of the status register asks the block to start the staged command. The block checks the request first. It rejects the command if the clock divider has not been set up, if the opcode is unknown, or if an earlier error is still pending. It also rejects a mass erase while any protection bit is left closed. A rejected command raises an access-error or protection-violation flag instead of starting.

An accepted command starts an abstract algorithm engine. The engine is a busy timer with a latency that software can set. The command-complete flag is low while the engine runs and returns high when the engine signals done. An optional interrupt follows the complete flag.

The block also snoops array reads. A read that arrives while a command is running returns invalid data. The first such read sets two fault flags and records its address, and both flags stay set until software clears them.

Top module: `fcmd_launch_ctrl`

## Requirements
- R1: Register map (offset: content). 0 is the divider: a write stores bits [6:0] and sets the divider-done flag, which reads at bit 7. 1 is status: bit 7 command complete, bit 5 access error, bit 4 protection violation. 2 is the index. 3 is the staged word at the current index, where word 0 bits [7:0] hold the opcode. 4 is protection, bits [4:0]. 5 is the interrupt enable, bit 0. 6 is the latency. 7 holds the fault flags in bits [1:0]. 8 is the fault address. 9 is the fault data. After reset, status reads 0x0080, the divider reads 0, the fault flags read 0 and the irq output is 0.
- R2: Writing word 0 with an opcode outside {0x08, 0x0B, 0x0D, 0x0E, 0x0F, 0x10, 0x11, 0x12, 0x13, 0x14, 0x15, 0x20} sets the access error. A later launch of that invalid opcode sets the access error again, and the complete flag stays 1.
- R3: Launching 0x08, 0x0B, 0x0F, 0x11, 0x12 or 0x20 before any divider write sets the access error and starts nothing. The other valid opcodes may launch without a divider write.
- R4: While either error flag is set, writes to the index and data registers and launch requests have no effect. Writing 1 to status bit 5 clears the access error, and writing 1 to bit 4 clears the protection violation.
- R5: Launching 0x08 while protection bits [4:0] are not all 1 sets the protection violation and starts nothing. With all five bits at 1, the command launches.
- R6: Writing an index larger than the opcode allows sets the access error and leaves the index unchanged. The limits are: 0x11 allows 4; 0x0F, 0x10 and 0x20 allow 2; 0x0D, 0x0E and 0x12 allow 1; every other opcode allows 0.
- R7: After an accepted launch, the complete flag reads 0 from the next cycle. It returns to 1 exactly L cycles after the launch edge, where L is the latency register value (0 counts as 1).
- R8: irq equals the complete flag AND the enable bit.
- R9: An array read while the complete flag is 0 and both fault flags are 0 sets both flags to 1 and captures the read address. The fault data register reads 0.
- R10: While either fault flag is set, later reads do not change the captured address. A read while the complete flag is 1 never sets a fault flag.
- R11: Writing 1 to bit 0 or bit 1 of the fault register clears that flag alone.
- R12: While a command runs, another launch does not restart the timer, and staging writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| arr_rd | input | 1 | Array read snoop valid |
| arr_rd_addr | input | 16 | Array read snoop address |
| irq | output | 1 | Command-complete interrupt |

## Verification
The hardest states to reach are the ones inside a running command. These include a fault capture followed by a second busy read and a partial flag clear, as well as a repeated launch or staging write in mid-run. The bench sets a long latency so that the window stays open. It then counts falling edges from the launch write, so that each snoop pulse, clear and second launch lands in a known cycle before done. Error blocking is reached in the same way: the bench deliberately raises an error, then shows that staged data and the complete flag stay unchanged.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
   localparam int OPC_W  = 8;
   localparam int PROT_W = 5;

   typedef enum logic [3:0] {
      REG_DIV   = 4'd0,
      REG_STAT  = 4'd1,
      REG_IDX   = 4'd2,
      REG_DATA  = 4'd3,
      REG_PROT  = 4'd4,
      REG_CFG   = 4'd5,
      REG_LAT   = 4'd6,
      REG_FLT   = 4'd7,
      REG_FADDR = 4'd8,
      REG_FDATA = 4'd9
   } reg_sel_e;

   localparam logic [OPC_W-1:0] OPC_MASS_ERASE = 8'h08;

   localparam int STAT_CMP = 7;
   localparam int STAT_ACC = 5;
   localparam int STAT_PV  = 4;

   function automatic logic opc_valid(input logic [OPC_W-1:0] op);
      case (op)
         8'h08, 8'h0B, 8'h0D, 8'h0E, 8'h0F, 8'h10,
         8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h20: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [2:0] opc_max_idx(input logic [OPC_W-1:0] op);
      case (op)
         8'h11:               return 3'd4;
         8'h0F, 8'h10, 8'h20: return 3'd2;
         8'h0D, 8'h0E, 8'h12: return 3'd1;
         default:             return 3'd0;
      endcase
   endfunction

   function automatic logic opc_needs_clk(input logic [OPC_W-1:0] op);
      case (op)
         8'h08, 8'h0B, 8'h0F, 8'h11, 8'h12, 8'h20: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/fcl_engine.sv
module fcl_engine #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] lat,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lat_eff;

   assign lat_eff = (lat == '0) ? CNT_W'(1) : lat;
   assign busy    = (cnt_q != '0);
   assign done    = (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (start) cnt_q <= lat_eff;
      else if (busy)  cnt_q <= cnt_q - CNT_W'(1);
   end
endmodule

// File: rtl/fcl_fault.sv
module fcl_fault #(
   parameter int FA_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            snoop_rd,
   input  logic [FA_W-1:0] snoop_addr,
   input  logic            array_busy,
   input  logic [1:0]      flt_clr,
   output logic [1:0]      flt_q,
   output logic [FA_W-1:0] faddr_q
);
   logic capture;

   assign capture = snoop_rd && array_busy && (flt_q == 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_q   <= 2'b00;
         faddr_q <= '0;
      end else if (capture) begin
         flt_q   <= 2'b11;
         faddr_q <= snoop_addr;
      end else begin
         flt_q   <= flt_q & ~flt_clr;
      end
   end
endmodule

// File: rtl/fcl_cmd_seq.sv
module fcl_cmd_seq
   import fcl_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 4,
   parameter int NUM_WORDS = 5,
   parameter int DIV_W     = 7,
   parameter int CNT_W     = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   input  logic                     eng_done,
   output logic                     cmd_complete,
   output logic                     acc_err,
   output logic                     prot_viol,
   output logic                     clk_init,
   output logic [DIV_W-1:0]         div_val,
   output logic [$clog2(NUM_WORDS)-1:0] idx_val,
   output logic [DATA_W-1:0]        slot_rd,
   output logic [PROT_W-1:0]        prot_val,
   output logic                     irq_en,
   output logic [CNT_W-1:0]         lat_val,
   output logic                     eng_start
);
   localparam int IDX_W = $clog2(NUM_WORDS);

   logic [DATA_W-1:0] slot_q [NUM_WORDS];
   logic [IDX_W-1:0]  idx_q;
   logic              cmp_q, acc_q, pv_q;
   logic              wr_div, wr_stat, wr_idx, wr_data, wr_prot, wr_cfg, wr_lat;
   logic              stage_ok, launch_req, idx_bad;
   logic              set_acc, set_pv, start;
   logic [OPC_W-1:0]  opcode;

   assign wr_div  = bus_wr && (bus_addr == ADDR_W'(REG_DIV));
   assign wr_stat = bus_wr && (bus_addr == ADDR_W'(REG_STAT));
   assign wr_idx  = bus_wr && (bus_addr == ADDR_W'(REG_IDX));
   assign wr_data = bus_wr && (bus_addr == ADDR_W'(REG_DATA));
   assign wr_prot = bus_wr && (bus_addr == ADDR_W'(REG_PROT));
   assign wr_cfg  = bus_wr && (bus_addr == ADDR_W'(REG_CFG));
   assign wr_lat  = bus_wr && (bus_addr == ADDR_W'(REG_LAT));

   assign opcode     = slot_q[0][OPC_W-1:0];
   assign stage_ok   = !(acc_q || pv_q) && cmp_q;
   assign launch_req = wr_stat && bus_wdata[STAT_CMP] && stage_ok;
   assign idx_bad    = int'(bus_wdata) > int'(opc_max_idx(opcode));

   always_comb begin
      set_acc = 1'b0;
      set_pv  = 1'b0;
      start   = 1'b0;
      if (wr_idx && stage_ok && idx_bad) set_acc = 1'b1;
      if (wr_data && stage_ok && (idx_q == '0) && !opc_valid(bus_wdata[OPC_W-1:0]))
         set_acc = 1'b1;
      if (launch_req) begin
         if (!opc_valid(opcode))                          set_acc = 1'b1;
         else if (opc_needs_clk(opcode) && !clk_init)     set_acc = 1'b1;
         else if (opcode == OPC_MASS_ERASE && !(&prot_val)) set_pv = 1'b1;
         else                                             start   = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= 1'b1;
         acc_q <= 1'b0;
         pv_q  <= 1'b0;
      end else begin
         acc_q <= (acc_q & ~(wr_stat && bus_wdata[STAT_ACC])) | set_acc;
         pv_q  <= (pv_q  & ~(wr_stat && bus_wdata[STAT_PV]))  | set_pv;
         if (start)         cmp_q <= 1'b0;
         else if (eng_done) cmp_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           idx_q <= '0;
      else if (wr_idx && stage_ok && !idx_bad) idx_q <= bus_wdata[IDX_W-1:0];
   end

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[g] <= '0;
         else if (wr_data && stage_ok && (idx_q == IDX_W'(g)))
            slot_q[g] <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_init <= 1'b0;
         div_val  <= '0;
         prot_val <= '0;
         irq_en   <= 1'b0;
         lat_val  <= CNT_W'(4);
      end else begin
         if (wr_div) begin
            clk_init <= 1'b1;
            div_val  <= bus_wdata[DIV_W-1:0];
         end
         if (wr_prot) prot_val <= bus_wdata[PROT_W-1:0];
         if (wr_cfg)  irq_en   <= bus_wdata[0];
         if (wr_lat)  lat_val  <= bus_wdata[CNT_W-1:0];
      end
   end

   assign cmd_complete = cmp_q;
   assign acc_err      = acc_q;
   assign prot_viol    = pv_q;
   assign idx_val      = idx_q;
   assign slot_rd      = slot_q[idx_q];
   assign eng_start    = start;
endmodule

// File: rtl/fcmd_launch_ctrl.sv
module fcmd_launch_ctrl
   import fcl_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 4,
   parameter int FA_W      = 16,
   parameter int CNT_W     = 8,
   parameter int NUM_WORDS = 5,
   parameter int DIV_W     = 7,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              arr_rd,
   input  logic [FA_W-1:0]   arr_rd_addr,
   output logic              irq
);
   localparam int IDX_W = $clog2(NUM_WORDS);

   if (NUM_WORDS < 5 || NUM_WORDS > 8) begin : g_bad_words
      $error("NUM_WORDS must be 5..8");
   end
   if (DIV_W > 7 || DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be 1..7");
   end
   if (DATA_W < 8 || DATA_W > 32 || FA_W > DATA_W || CNT_W > DATA_W || CNT_W < 2) begin : g_bad_width
      $error("inconsistent data, address or counter widths");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must be at least 4");
   end

   logic              cmd_complete, acc_err, prot_viol, clk_init, irq_en;
   logic              eng_start, eng_busy, eng_done, wr_flt;
   logic [DIV_W-1:0]  div_val;
   logic [IDX_W-1:0]  idx_val;
   logic [DATA_W-1:0] slot_rd;
   logic [PROT_W-1:0] prot_val;
   logic [CNT_W-1:0]  lat_val;
   logic [1:0]        flt_flags;
   logic [FA_W-1:0]   flt_addr;

   fcl_cmd_seq #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS),
      .DIV_W(DIV_W), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .eng_done(eng_done), .cmd_complete(cmd_complete),
      .acc_err(acc_err), .prot_viol(prot_viol), .clk_init(clk_init),
      .div_val(div_val), .idx_val(idx_val), .slot_rd(slot_rd),
      .prot_val(prot_val), .irq_en(irq_en), .lat_val(lat_val),
      .eng_start(eng_start)
   );

   fcl_engine #(.CNT_W(CNT_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(eng_start), .lat(lat_val),
      .busy(eng_busy), .done(eng_done)
   );

   assign wr_flt = bus_wr && (bus_addr == ADDR_W'(REG_FLT));

   fcl_fault #(.FA_W(FA_W)) u_flt (
      .clk(clk), .rst_n(rst_n), .snoop_rd(arr_rd), .snoop_addr(arr_rd_addr),
      .array_busy(!cmd_complete), .flt_clr({2{wr_flt}} & bus_wdata[1:0]),
      .flt_q(flt_flags), .faddr_q(flt_addr)
   );

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= cmd_complete && irq_en;
      end
   end else begin : g_irq_comb
      assign irq = cmd_complete && irq_en;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(REG_DIV): begin
            bus_rdata[DIV_W-1:0] = div_val;
            bus_rdata[7]         = clk_init;
         end
         ADDR_W'(REG_STAT): begin
            bus_rdata[STAT_CMP] = cmd_complete;
            bus_rdata[STAT_ACC] = acc_err;
            bus_rdata[STAT_PV]  = prot_viol;
         end
         ADDR_W'(REG_IDX):   bus_rdata[IDX_W-1:0]  = idx_val;
         ADDR_W'(REG_DATA):  bus_rdata             = slot_rd;
         ADDR_W'(REG_PROT):  bus_rdata[PROT_W-1:0] = prot_val;
         ADDR_W'(REG_CFG):   bus_rdata[0]          = irq_en;
         ADDR_W'(REG_LAT):   bus_rdata[CNT_W-1:0]  = lat_val;
         ADDR_W'(REG_FLT):   bus_rdata[1:0]        = flt_flags;
         ADDR_W'(REG_FADDR): bus_rdata[FA_W-1:0]   = flt_addr;
         default:            bus_rdata             = '0;
      endcase
   end
endmodule

// File: rtl/fcl_checker.sv
module fcl_checker #(
   parameter int FA_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            complete,
   input logic            busy,
   input logic            done,
   input logic            accerr,
   input logic            pviol,
   input logic [1:0]      flt,
   input logic [FA_W-1:0] faddr,
   input logic            arr_rd,
   input logic [FA_W-1:0] arr_addr,
   input logic            irq
);
   p_complete_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      complete != busy);

   p_done_completes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> complete);

   p_err_blocks_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((accerr || pviol) && complete) |=> complete);

   p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!complete && !$past(complete)) |-> !irq);

   p_fault_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_rd && !complete && flt == 2'b00) |=> (flt == 2'b11 && faddr == $past(arr_addr)));

   p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flt != 2'b00) |=> $stable(faddr));

   p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_rd && complete && flt == 2'b00) |=> (flt == 2'b00));
endmodule

bind fcmd_launch_ctrl fcl_checker #(.FA_W(FA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .complete(cmd_complete), .busy(eng_busy),
   .done(eng_done), .accerr(acc_err), .pviol(prot_viol), .flt(flt_flags),
   .faddr(flt_addr), .arr_rd(arr_rd), .arr_addr(arr_rd_addr), .irq(irq)
);

// File: tb/fcmd_launch_ctrl_bench.sv
`timescale 1ns/1ps
module fcmd_launch_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = 4'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        arr_rd = 1'b0;
   logic [15:0] arr_rd_addr = 16'd0;
   logic        irq;
   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   fcmd_launch_ctrl u_fcmd_launch_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_rd(arr_rd),
      .arr_rd_addr(arr_rd_addr), .irq(irq)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic snoop(input logic [15:0] a);
      arr_rd      = 1'b1;
      arr_rd_addr = a;
      @(negedge clk);
      arr_rd      = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic stage_op(input logic [15:0] op);
      wr(4'd2, 16'd0);
      wr(4'd3, op);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      rd(4'd1, v); chk("R1 status after reset", v, 16'h0080);
      rd(4'd0, v); chk("R1 divider after reset", v, 16'h0000);
      rd(4'd7, v); chk("R1 fault flags after reset", v, 16'h0000);
      chk("R1 irq after reset", {15'd0, irq}, 16'h0000);
   endtask

   task automatic t_clk_required;
      logic [15:0] v;
      stage_op(16'h0012);
      wr(4'd1, 16'h0080);
      rd(4'd1, v); chk("R3 erase without divider rejected", v, 16'h00A0);
      wr(4'd1, 16'h0020);
      rd(4'd1, v); chk("R4 access error cleared", v, 16'h0080);
      wr(4'd6, 16'd3);
      stage_op(16'h0015);
      wr(4'd1, 16'h0080);
      rd(4'd1, v); chk("R3 query launches without divider", v, 16'h0000);
      idle(4);
      rd(4'd1, v); chk("R3 query completes", v, 16'h0080);
      wr(4'd0, 16'h0010);
      rd(4'd0, v); chk("R1 divider write sets done flag", v, 16'h0090);
   endtask

   task automatic t_opcode_invalid;
      logic [15:0] v;
      stage_op(16'h0009);
      rd(4'd1, v); chk("R2 invalid opcode flags error", v, 16'h00A0);
      wr(4'd1, 16'h0020);
      wr(4'd1, 16'h0080);
      rd(4'd1, v); chk("R2 invalid opcode launch rejected", v, 16'h00A0);
      wr(4'd1, 16'h0020);
      stage_op(16'h0020);
      rd(4'd1, v); chk("R2 valid opcode accepted", v, 16'h0080);
   endtask

   task automatic t_index_limit;
      logic [15:0] v;
      stage_op(16'h0012);
      wr(4'd2, 16'd1);
      rd(4'd2, v); chk("R6 index 1 allowed for 0x12", v, 16'd1);
      wr(4'd2, 16'd2);
      rd(4'd1, v); chk("R6 index 2 rejected for 0x12", v, 16'h00A0);
      rd(4'd2, v); chk("R6 index unchanged", v, 16'd1);
      wr(4'd1, 16'h0020);
      stage_op(16'h0011);
      wr(4'd2, 16'd4);
      rd(4'd2, v); chk("R6 index 4 allowed for 0x11", v, 16'd4);
      wr(4'd3, 16'hBEEF);
      rd(4'd3, v); chk("R6 word 4 stored", v, 16'hBEEF);
      wr(4'd2, 16'd5);
      rd(4'd1, v); chk("R6 index 5 rejected for 0x11", v, 16'h00A0);
   endtask

   task automatic t_err_blocks;
      logic [15:0] v;
      wr(4'd3, 16'h1111);
      rd(4'd3, v); chk("R4 data write ignored under error", v, 16'hBEEF);
      wr(4'd2, 16'd0);
      rd(4'd2, v); chk("R4 index write ignored under error", v, 16'd4);
      wr(4'd1, 16'h0080);
      rd(4'd1, v); chk("R4 launch ignored under error", v, 16'h00A0);
      wr(4'd1, 16'h0020);
      rd(4'd1, v); chk("R4 clear restores status", v, 16'h0080);
   endtask

   task automatic t_mass_erase;
      logic [15:0] v;
      stage_op(16'h0008);
      wr(4'd4, 16'h000F);
      wr(4'd1, 16'h0080);
      rd(4'd1, v); chk("R5 mass erase with protection closed", v, 16'h0090);
      wr(4'd1, 16'h0010);
      rd(4'd1, v); chk("R4 protection violation cleared", v, 16'h0080);
      wr(4'd4, 16'h001F);
      wr(4'd1, 16'h0080);
      rd(4'd1, v); chk("R5 mass erase with protection open", v, 16'h0000);
      idle(4);
      rd(4'd1, v); chk("R5 mass erase completes", v, 16'h0080);
   endtask

   task automatic t_timing_irq;
      logic [15:0] v;
      wr(4'd5, 16'd1);
      wr(4'd6, 16'd5);
      stage_op(16'h0012);
      chk("R8 irq with complete and enable", {15'd0, irq}, 16'd1);
      wr(4'd1, 16'h0080);
      rd(4'd1, v); chk("R7 complete low after launch", v, 16'h0000);
      chk("R8 irq low while busy", {15'd0, irq}, 16'd0);
      idle(4);
      rd(4'd1, v); chk("R7 still busy at L-1", v, 16'h0000);
      idle(1);
      rd(4'd1, v); chk("R7 complete at L", v, 16'h0080);
      chk("R8 irq on completion", {15'd0, irq}, 16'd1);
      wr(4'd5, 16'd0);
      chk("R8 irq off when disabled", {15'd0, irq}, 16'd0);
   endtask

   task automatic t_busy_relaunch;
      logic [15:0] v;
      wr(4'd6, 16'd6);
      wr(4'd1, 16'h0080);
      idle(2);
      wr(4'd1, 16'h0080);
      wr(4'd3, 16'h0009);
      idle(1);
      rd(4'd1, v); chk("R12 busy until original end", v, 16'h0000);
      idle(1);
      rd(4'd1, v); chk("R12 second launch did not restart", v, 16'h0080);
      rd(4'd3, v); chk("R12 staging write ignored while busy", v, 16'h0012);
   endtask

   task automatic t_fault;
      logic [15:0] v;
      wr(4'd6, 16'd8);
      wr(4'd1, 16'h0080);
      snoop(16'h1234);
      rd(4'd7, v); chk("R9 both fault flags set", v, 16'h0003);
      rd(4'd8, v); chk("R9 fault address captured", v, 16'h1234);
      rd(4'd9, v); chk("R9 fault data zero", v, 16'h0000);
      snoop(16'h5678);
      rd(4'd8, v); chk("R10 second busy read keeps address", v, 16'h1234);
      wr(4'd7, 16'h0001);
      rd(4'd7, v); chk("R11 single flag clear", v, 16'h0002);
      snoop(16'h9ABC);
      rd(4'd8, v); chk("R10 read with one flag keeps address", v, 16'h1234);
      rd(4'd7, v); chk("R10 flags not re-set", v, 16'h0002);
      idle(4);
      rd(4'd1, v); chk("R7 long command completes", v, 16'h0080);
      wr(4'd7, 16'h0003);
      rd(4'd7, v); chk("R11 flags cleared", v, 16'h0000);
      snoop(16'h0AAA);
      rd(4'd7, v); chk("R10 idle read sets no flag", v, 16'h0000);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_clk_required();
      t_opcode_invalid();
      t_index_limit();
      t_err_blocks();
      t_mass_erase();
      t_timing_irq();
      t_busy_relaunch();
      t_fault();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule